// File: doc/BRIEF.md
# Tensor Unfolding and Gram Symmetrization Unit

This block takes one third-order sample tensor of 4 x 4 x 40 signed fixed-point values and forms the three mode unfoldings of it. It turns each unfolding straight into its Gram matrix, the product of the matrix with its own transpose. The three small square Gram matrices go to a later eigen or singular-value stage.

Elements enter on a valid/ready stream and are written into a register store. The store is made of 16-entry banks, so two elements can be read in every cycle. After the whole tensor has arrived, an address generator walks the column index of each unfolding. It feeds pairs of elements into a single multiply-accumulate pipeline, so unfolding and symmetrization run as one overlapped stream. Each finished Gram entry leaves on an output strobe, tagged with its mode, row and column. A one-cycle done pulse closes each sample. As soon as the last read has left the store, a new tensor may start loading while the pipeline drains.

Top module: `tensorGramUnit`

## Requirements
- R1: After reset, `inReady` is 1, and both `outValid` and `sampleDone` are 0.
- R2: The block accepts exactly 640 elements per sample, one on each cycle where `inValid` and `inReady` are both high. Element (i1,i2,i3) sits at arrival position i1 + 4*i2 + 16*i3, so i1 varies fastest. `inReady` is low in the cycle after the 640th accept. It stays low until the store has been read in full, and `inValid` has no effect while it is low.
- R3: Mode tag 0 carries the 4 x 4 Gram matrix G[a][b] = sum over i2,i3 of T(a,i2,i3)*T(b,i2,i3).
- R4: Mode tag 1 carries the 4 x 4 Gram matrix G[a][b] = sum over i1,i3 of T(i1,a,i3)*T(i1,b,i3).
- R5: Mode tag 2 carries the 40 x 40 Gram matrix G[a][b] = sum over i1,i2 of T(i1,i2,a)*T(i1,i2,b).
- R6: Each sample emits exactly 1632 entries. All of mode 0 comes first, then mode 1, then mode 2. Within a mode the order is row-major, and every entry has `outRow`/`outCol` tags equal to its indices.
- R7: Values are two's complement with 12 fractional bits. Each entry is summed exactly, then has 2^11 added and is shifted right arithmetically by 12, so ties round toward plus infinity.
- R8: A rounded result above 0x7FFFFF gives 0x7FFFFF, and one below -0x800000 gives 0x800000.
- R9: `sampleDone` is high for exactly one cycle, the cycle right after the last mode-2 entry is presented.
- R10: `inReady` rises again one cycle before the last entry of a sample appears. It is high during no other output cycle, and a tensor loaded from that moment gives correct results for both samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input element valid |
| inReady | output | 1 | Block can take an element |
| inData | input | 24 | Input element, signed, 12 fractional bits |
| outValid | output | 1 | Gram entry valid this cycle |
| outMode | output | 2 | Unfolding mode of the entry (0, 1, 2) |
| outRow | output | 6 | Row index of the entry |
| outCol | output | 6 | Column index of the entry |
| outData | output | 24 | Rounded, saturated Gram entry |
| sampleDone | output | 1 | One-cycle pulse after the final entry |

## Verification
The hardest case to reach is the handover between samples. A new tensor starts overwriting the banks while the last two reads of the old one are still in the pipeline. The bench loads the next tensor as soon as `inReady` rises, with no gap, and checks every entry of both samples. Saturation in both directions is forced by a tensor of plus and minus 8.0 values, and rounding ties come from a sparse tensor of small raw values. Each sample sweeps all 1632 entries against sums the bench computes itself.

// File: rtl/tensorGramPkg.sv
package tensorGramPkg;
  localparam int DIM1 = 4;
  localparam int DIM2 = 4;
  localparam int DIM3 = 40;
  localparam int DATA_W = 24;
  localparam int FRAC_W = 12;
  localparam int BANK_DEPTH = 16;
  localparam int TOTAL = DIM1 * DIM2 * DIM3;
  localparam int NUM_BANKS = TOTAL / BANK_DEPTH;
  localparam int IDX_W = $clog2(TOTAL);
  localparam int OFF_W = $clog2(BANK_DEPTH);
  localparam int BANK_W = IDX_W - OFF_W;
  localparam int DIM_MAX = (DIM1 > DIM2) ? ((DIM1 > DIM3) ? DIM1 : DIM3) : ((DIM2 > DIM3) ? DIM2 : DIM3);
  localparam int DIM_W = $clog2(DIM_MAX + 1);
  localparam int MODE_W = 2;
  localparam int ACC_W = 2 * DATA_W + $clog2(TOTAL) + 1;

  typedef logic [DIM_W-1:0] dim_t;
  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t MODE_LAST = mode_t'(2);

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic  wrEn;
    idx_t  wrIdx;
    logic  rdValid;
    idx_t  rdIdxA;
    idx_t  rdIdxB;
    logic  first;
    logic  last;
    logic  lastOfSample;
    mode_t mode;
    dim_t  row;
    dim_t  col;
  } ctrlStrobes_t;

  // Largest row index of the unfolding for a mode
  function automatic dim_t rowMax(mode_t m);
    case (m)
      mode_t'(0): return dim_t'(DIM1 - 1);
      mode_t'(1): return dim_t'(DIM2 - 1);
      default:    return dim_t'(DIM3 - 1);
    endcase
  endfunction

  // Inner (faster) column sub-index limit
  function automatic dim_t innerMax(mode_t m);
    case (m)
      mode_t'(0): return dim_t'(DIM2 - 1);
      default:    return dim_t'(DIM1 - 1);
    endcase
  endfunction

  // Outer (slower) column sub-index limit
  function automatic dim_t outerMax(mode_t m);
    case (m)
      mode_t'(2): return dim_t'(DIM2 - 1);
      default:    return dim_t'(DIM3 - 1);
    endcase
  endfunction

  function automatic idx_t flatIdx(dim_t i1, dim_t i2, dim_t i3);
    return idx_t'(i1) + idx_t'(DIM1) * idx_t'(i2) + idx_t'(DIM1 * DIM2) * idx_t'(i3);
  endfunction
endpackage

// File: rtl/tensorGramCtrl.sv
module tensorGramCtrl
  import tensorGramPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output logic         inReady,
  output ctrlStrobes_t strobes
);
  typedef enum logic {ST_LOAD, ST_RUN} state_t;

  state_t state;
  idx_t   wrCnt;
  mode_t  modeQ;
  dim_t   rowQ, colQ, inQ, outQ;
  logic   inEnd, outEnd, colEnd, rowEnd, modeEnd, running;
  dim_t   aI1, aI2, aI3, bI1, bI2, bI3;

  assign running = (state == ST_RUN);
  assign inReady = (state == ST_LOAD);
  assign inEnd   = (inQ == innerMax(modeQ));
  assign outEnd  = (outQ == outerMax(modeQ));
  assign colEnd  = (colQ == rowMax(modeQ));
  assign rowEnd  = (rowQ == rowMax(modeQ));
  assign modeEnd = (modeQ == MODE_LAST);

  // Index remapping per unfolding mode
  always_comb begin
    case (modeQ)
      mode_t'(0): begin
        aI1 = rowQ; aI2 = inQ;  aI3 = outQ;
        bI1 = colQ; bI2 = inQ;  bI3 = outQ;
      end
      mode_t'(1): begin
        aI1 = inQ;  aI2 = rowQ; aI3 = outQ;
        bI1 = inQ;  bI2 = colQ; bI3 = outQ;
      end
      default: begin
        aI1 = inQ;  aI2 = outQ; aI3 = rowQ;
        bI1 = inQ;  bI2 = outQ; bI3 = colQ;
      end
    endcase
  end

  always_comb begin
    strobes.wrEn         = inReady && inValid;
    strobes.wrIdx        = wrCnt;
    strobes.rdValid      = running;
    strobes.rdIdxA       = flatIdx(aI1, aI2, aI3);
    strobes.rdIdxB       = flatIdx(bI1, bI2, bI3);
    strobes.first        = running && (inQ == '0) && (outQ == '0);
    strobes.last         = running && inEnd && outEnd;
    strobes.lastOfSample = running && inEnd && outEnd && colEnd && rowEnd && modeEnd;
    strobes.mode         = modeQ;
    strobes.row          = rowQ;
    strobes.col          = colQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_LOAD;
      wrCnt <= '0;
      modeQ <= '0;
      rowQ  <= '0;
      colQ  <= '0;
      inQ   <= '0;
      outQ  <= '0;
    end else begin
      case (state)
        ST_LOAD: begin
          if (inValid) begin
            if (wrCnt == idx_t'(TOTAL - 1)) begin
              wrCnt <= '0;
              state <= ST_RUN;
            end else begin
              wrCnt <= wrCnt + 1'b1;
            end
          end
        end
        default: begin
          if (!inEnd) inQ <= inQ + 1'b1;
          else begin
            inQ <= '0;
            if (!outEnd) outQ <= outQ + 1'b1;
            else begin
              outQ <= '0;
              if (!colEnd) colQ <= colQ + 1'b1;
              else begin
                colQ <= '0;
                if (!rowEnd) rowQ <= rowQ + 1'b1;
                else begin
                  rowQ <= '0;
                  if (!modeEnd) modeQ <= modeQ + 1'b1;
                  else begin
                    modeQ <= '0;
                    state <= ST_LOAD;
                  end
                end
              end
            end
          end
        end
      endcase
    end
  end

  // R2
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.wrEn && strobes.rdValid))
    else $error("store written while being read");

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrEn && strobes.wrIdx == idx_t'(TOTAL - 1)) |=> !inReady)
    else $error("ready stayed high after full tensor");

  // R6
  sample_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lastOfSample |-> (strobes.last && strobes.mode == MODE_LAST))
    else $error("sample ended outside final mode");
endmodule

// File: rtl/tensorGramDatapath.sv
module tensorGramDatapath
  import tensorGramPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  ctrlStrobes_t      strobes,
  output logic              outValid,
  output mode_t             outMode,
  output dim_t              outRow,
  output dim_t              outCol,
  output logic [DATA_W-1:0] outData,
  output logic              sampleDone
);
  localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

  logic [DATA_W-1:0] bankOutA [NUM_BANKS];
  logic [DATA_W-1:0] bankOutB [NUM_BANKS];

  // Banked register store, 16 consecutive elements per bank
  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    logic [DATA_W-1:0] bankRegs [BANK_DEPTH];
    always_ff @(posedge clk) begin
      if (strobes.wrEn && strobes.wrIdx[IDX_W-1:OFF_W] == BANK_W'(gb))
        bankRegs[strobes.wrIdx[OFF_W-1:0]] <= inData;
    end
    assign bankOutA[gb] = bankRegs[strobes.rdIdxA[OFF_W-1:0]];
    assign bankOutB[gb] = bankRegs[strobes.rdIdxB[OFF_W-1:0]];
  end

  logic signed [DATA_W-1:0]   opAQ, opBQ;
  logic                       s1Valid, s1First, s1Last, s1Final;
  mode_t                      s1Mode;
  dim_t                       s1Row, s1Col;
  logic signed [2*DATA_W-1:0] prod;
  logic signed [ACC_W-1:0]    prodExt, accQ, accNext, rndSum, rndShift;
  logic [DATA_W-1:0]          satVal;
  logic                       outFinal;

  // Operand stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAQ    <= '0;
      opBQ    <= '0;
      s1Valid <= 1'b0;
      s1First <= 1'b0;
      s1Last  <= 1'b0;
      s1Final <= 1'b0;
      s1Mode  <= '0;
      s1Row   <= '0;
      s1Col   <= '0;
    end else begin
      opAQ    <= bankOutA[strobes.rdIdxA[IDX_W-1:OFF_W]];
      opBQ    <= bankOutB[strobes.rdIdxB[IDX_W-1:OFF_W]];
      s1Valid <= strobes.rdValid;
      s1First <= strobes.first;
      s1Last  <= strobes.last;
      s1Final <= strobes.lastOfSample;
      s1Mode  <= strobes.mode;
      s1Row   <= strobes.row;
      s1Col   <= strobes.col;
    end
  end

  // Multiply, accumulate, round and saturate
  always_comb begin
    prod     = opAQ * opBQ;
    prodExt  = {{(ACC_W - 2 * DATA_W){prod[2*DATA_W-1]}}, prod};
    accNext  = (s1First ? '0 : accQ) + prodExt;
    rndSum   = accNext + HALF;
    rndShift = rndSum >>> FRAC_W;
    if (rndShift > SAT_HI)      satVal = SAT_HI[DATA_W-1:0];
    else if (rndShift < SAT_LO) satVal = SAT_LO[DATA_W-1:0];
    else                        satVal = rndShift[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ       <= '0;
      outValid   <= 1'b0;
      outMode    <= '0;
      outRow     <= '0;
      outCol     <= '0;
      outData    <= '0;
      outFinal   <= 1'b0;
      sampleDone <= 1'b0;
    end else begin
      outValid   <= 1'b0;
      sampleDone <= outValid && outFinal;
      if (s1Valid) begin
        accQ <= accNext;
        if (s1Last) begin
          outValid <= 1'b1;
          outData  <= satVal;
          outMode  <= s1Mode;
          outRow   <= s1Row;
          outCol   <= s1Col;
          outFinal <= s1Final;
        end
      end
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleDone |=> !sampleDone)
    else $error("done held longer than one cycle");

  // R9
  done_after_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleDone |-> ($past(outValid) && $past(outMode) == MODE_LAST))
    else $error("done without preceding final entry");

  // R6
  out_tag_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outMode <= MODE_LAST && outRow <= rowMax(outMode) && outCol <= rowMax(outMode)))
    else $error("output tag out of range");
endmodule

// File: rtl/tensorGramUnit.sv
module tensorGramUnit
  import tensorGramPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [MODE_W-1:0] outMode,
  output logic [DIM_W-1:0]  outRow,
  output logic [DIM_W-1:0]  outCol,
  output logic [DATA_W-1:0] outData,
  output logic              sampleDone
);
  ctrlStrobes_t strobes;

  tensorGramCtrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .strobes (strobes)
  );

  tensorGramDatapath dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .inData     (inData),
    .strobes    (strobes),
    .outValid   (outValid),
    .outMode    (outMode),
    .outRow     (outRow),
    .outCol     (outCol),
    .outData    (outData),
    .sampleDone (sampleDone)
  );
endmodule

// File: tb/tensorGramUnit_tb_top.sv
module tensorGramUnit_tb_top;
  import tensorGramPkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [DATA_W-1:0] inData = '0;
  logic              outValid;
  logic [MODE_W-1:0] outMode;
  logic [DIM_W-1:0]  outRow, outCol;
  logic [DATA_W-1:0] outData;
  logic              sampleDone;

  always #2 clk = ~clk;

  tensorGramUnit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outMode(outMode), .outRow(outRow), .outCol(outCol),
    .outData(outData), .sampleDone(sampleDone)
  );

  int    nChecks = 0;
  int    nFails = 0;
  int    tens [TOTAL];
  int    expG [3][DIM_MAX][DIM_MAX];
  string outLabel = "";
  int    samplesDone = 0;
  int    cyc = 0;
  int    lastOutCyc = -10;
  int    entries = 0;
  int    readyDuring = 0;
  int    seqM = 0, seqR = 0, seqC = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rowsOf(int m);
    return (m == 0) ? DIM1 : (m == 1) ? DIM2 : DIM3;
  endfunction

  function automatic int elem(int m, int r, int x, int y);
    if (m == 0) return tens[r + DIM1 * x + DIM1 * DIM2 * y];
    if (m == 1) return tens[x + DIM1 * r + DIM1 * DIM2 * y];
    return tens[x + DIM1 * y + DIM1 * DIM2 * r];
  endfunction

  task automatic computeExpected();
    for (int m = 0; m < 3; m++) begin
      int xN = (m == 0) ? DIM2 : DIM1;
      int yN = (m == 2) ? DIM2 : DIM3;
      for (int a = 0; a < rowsOf(m); a++)
        for (int b = 0; b < rowsOf(m); b++) begin
          longint s = 0;
          longint r;
          for (int x = 0; x < xN; x++)
            for (int y = 0; y < yN; y++)
              s += longint'(elem(m, a, x, y)) * longint'(elem(m, b, x, y));
          r = (s + 2048) >>> 12;
          if (r > 64'sd8388607) r = 64'sd8388607;
          if (r < -64'sd8388608) r = -64'sd8388608;
          expG[m][a][b] = int'(r);
        end
    end
  endtask

  task automatic loadTensor(input bit bubbles, input string label);
    int n = 0;
    int tick = 0;
    while (n < TOTAL) begin
      @(negedge clk);
      tick++;
      if (inReady && !(bubbles && (tick % 5 == 2))) begin
        inValid = 1'b1;
        inData = DATA_W'(tens[n]);
        n++;
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    computeExpected();
    outLabel = label;
    // R2: junk offered while not ready must be ignored
    inValid = 1'b1;
    inData = 24'h5A5A5A;
    check(inReady == 1'b0, "R2 ready low after full tensor", inReady, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(inReady == 1'b0, "R2 ready low during readout", inReady, 0);
    end
    inValid = 1'b0;
  endtask

  // Output monitor
  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (outValid) begin
        string rq;
        rq = (seqM == 0) ? "R3" : (seqM == 1) ? "R4" : "R5";
        check(outMode == MODE_W'(seqM) && outRow == DIM_W'(seqR) && outCol == DIM_W'(seqC),
              "R6 entry tags", {outMode, outRow, outCol}, {MODE_W'(seqM), DIM_W'(seqR), DIM_W'(seqC)});
        check($signed(outData) == expG[seqM][seqR][seqC], {rq, " ", outLabel},
              $signed(outData), expG[seqM][seqR][seqC]);
        entries++;
        if (inReady) readyDuring++;
        lastOutCyc = cyc;
        if (seqC + 1 < rowsOf(seqM)) seqC++;
        else begin
          seqC = 0;
          if (seqR + 1 < rowsOf(seqM)) seqR++;
          else begin
            seqR = 0;
            seqM = (seqM == 2) ? 0 : seqM + 1;
          end
        end
      end
      if (sampleDone) begin
        check(cyc == lastOutCyc + 1, "R9 done one cycle after last entry", cyc - lastOutCyc, 1);
        check(entries == 1632, "R6 entry count", entries, 1632);
        check(readyDuring == 1, "R10 ready only with final entry", readyDuring, 1);
        entries = 0;
        readyDuring = 0;
        samplesDone++;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog expired", samplesDone, 4);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R1 ready after reset", inReady, 1);
    check(outValid == 1'b0, "R1 no output after reset", outValid, 0);
    check(sampleDone == 1'b0, "R1 no done after reset", sampleDone, 0);

    // Sample A: moderate values, input bubbles
    for (int n = 0; n < TOTAL; n++) tens[n] = ((n * 73 + 19) % 8192) - 4096;
    loadTensor(1'b1, "R7 sampleA");

    // Sample B: +/-8.0 pattern, saturates both ways (R8), loaded back-to-back (R10)
    for (int n = 0; n < TOTAL; n++) tens[n] = ((n % DIM1) % 2 == 1) ? -32768 : 32768;
    loadTensor(1'b0, "R8 R10 sampleB");

    // Sample C: sparse small raw values, rounding ties (R7)
    for (int n = 0; n < TOTAL; n++) tens[n] = 0;
    tens[0] = 64;
    tens[1] = -32;
    tens[0 + 4 * 1 + 16 * 5] = 45;
    tens[2 + 4 * 3 + 16 * 39] = 91;
    tens[3 + 4 * 2 + 16 * 17] = -1;
    loadTensor(1'b0, "R7 sampleC");

    // Sample D: wide-range values, mixed saturation
    for (int n = 0; n < TOTAL; n++) tens[n] = ((n * 1103 + 7) % 65536) - 32768;
    loadTensor(1'b1, "R8 sampleD");

    wait (samplesDone == 4);
    repeat (3) @(negedge clk);
    check(inReady == 1'b1, "R10 ready after final sample", inReady, 1);
    check(outValid == 1'b0, "R6 no stray output", outValid, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule